// File: doc/BRIEF.md
# Event Completion Order Recorder

This block watches up to sixteen conversion events. Each event belongs to one of two timers. When an enabled event reports completion, the block records where that completion fell in the sequence. The record for each event is a small rank value, and the sixteen rank values are presented side by side. The block also keeps one completion flag per timer. A timer's flag rises once every enabled event assigned to that timer has completed since that timer's last trigger. Each flag can raise an interrupt if its mask bit is set.

Software can wipe all ranks with a single clear bit. The ranks can also be wiped by hardware, when auto-clear is enabled and the timer trigger picked by a select input arrives. The per-timer tracking runs independently of the rank clear. It restarts only on that timer's own trigger.

Top module: `evt_order_rec`

## Requirements
- R1: After reset every rank field, both timer flags and both interrupt outputs are 0.
- R2: Event i owns bits [5i+4:5i] of `order_flat`. In that field, 0 means not completed. A `evt_done` pulse on an enabled event with a zero rank stores (completions so far + 1), and the value is visible in the cycle after the pulse. The first completion is therefore 1.
- R3: When several enabled, unrecorded events pulse in the same cycle, they take consecutive ranks in ascending event index.
- R4: A further pulse from an event that already holds a nonzero rank leaves its rank unchanged. It also does not advance the count used for later ranks.
- R5: A pulse on an event whose `evt_en` bit is 0 records nothing and advances no count.
- R6: `sw_clr` zeroes every rank and the completion count in the next cycle. Completions pulsed in that same cycle are not recorded.
- R7: With `auto_clr_en`=1, a pulse on `tmr_trig[clr_trig_sel]` clears the ranks exactly as R6 does. A trigger on the other timer, or any trigger while `auto_clr_en`=0, leaves the ranks untouched.
- R8: Event i belongs to timer `evt_tmr_flat[i]` (0 or 1). `tmr_done[t]` becomes 1 in the cycle after the pulse that makes every enabled event of timer t complete since t's last trigger. At least one such event must be enabled. The flag then holds.
- R9: A pulse on `tmr_trig[t]` clears `tmr_done[t]` in the next cycle. Completions of t's events in the trigger cycle do not count toward the new round.
- R10: `irq[t]` equals `tmr_done[t]` AND `irq_en[t]`, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_done | input | 16 | Per-event completion pulse |
| evt_en | input | 16 | Per-event enable |
| evt_tmr_flat | input | 16 | Timer owning each event |
| tmr_trig | input | 2 | Per-timer trigger pulse |
| sw_clr | input | 1 | Software rank clear |
| auto_clr_en | input | 1 | Enable hardware rank clear on trigger |
| clr_trig_sel | input | 1 | Timer whose trigger drives the hardware clear |
| irq_en | input | 2 | Per-timer interrupt mask |
| order_flat | output | 80 | Sixteen 5-bit completion ranks |
| tmr_done | output | 2 | Per-timer all-complete flag |
| irq | output | 2 | Masked completion interrupts |

## Verification
Two pairs of functions can coincide, and the bench drives each pair in a single cycle. The first pair is a rank clear and a completion pulse. The bench raises `sw_clr` together with an event's completion, and later raises the selected trigger, with auto-clear on, together with a repeat completion. It then checks that the rank vector comes back all zero, with no rank for the colliding event. The second pair is a timer trigger and a completion of one of that timer's events. The bench expects the flag to drop, and expects that completion not to count toward the next round.

// File: rtl/evo_pkg.sv
package evo_pkg;

  // Source of a rank wipe in the current cycle
  typedef enum logic [1:0] {
    CLR_NONE = 2'd0,
    CLR_SW   = 2'd1,
    CLR_AUTO = 2'd2
  } clr_src_e;

endpackage

// File: rtl/evo_rank_alloc.sv
// Combinational rank allocation: each fresh completion receives
// base + 1 + (number of fresh completions at lower indices).
module evo_rank_alloc #(
  parameter int NUM_EVT = 16,
  parameter int RANK_W  = 5
) (
  input  logic [NUM_EVT-1:0]             fresh,
  input  logic [RANK_W-1:0]              base,
  output logic [NUM_EVT-1:0][RANK_W-1:0] rank_new,
  output logic [RANK_W-1:0]              total
);

  logic [NUM_EVT:0][RANK_W-1:0] pre;

  assign pre[0] = '0;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chain
    assign pre[i+1]    = pre[i] + RANK_W'(fresh[i]);
    assign rank_new[i] = base + pre[i] + RANK_W'(1);
  end

  assign total = pre[NUM_EVT];

endmodule

// File: rtl/evo_order_regs.sv
// Rank storage and completion counter.
module evo_order_regs
  import evo_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int RANK_W  = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  clr_src_e                       clr_src,
  input  logic [NUM_EVT-1:0]             fresh,
  input  logic [NUM_EVT-1:0][RANK_W-1:0] rank_new,
  input  logic [RANK_W-1:0]              total,
  output logic [RANK_W-1:0]              cnt,
  output logic [NUM_EVT-1:0]             recorded,
  output logic [NUM_EVT*RANK_W-1:0]      order_flat
);

  logic [NUM_EVT-1:0][RANK_W-1:0] rank_q, rank_d;
  logic [RANK_W-1:0]              cnt_q, cnt_d;
  logic                           upd;

  assign upd = (clr_src != CLR_NONE) || (|fresh);

  always_comb begin
    rank_d = rank_q;
    cnt_d  = cnt_q;
    if (clr_src != CLR_NONE) begin
      rank_d = '0;
      cnt_d  = '0;
    end else begin
      for (int i = 0; i < NUM_EVT; i++) begin
        if (fresh[i]) rank_d[i] = rank_new[i];
      end
      cnt_d = cnt_q + total;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rank_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      rank_q <= rank_d;
      cnt_q  <= cnt_d;
    end
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_rec
    assign recorded[i] = |rank_q[i];

    AST_RANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (recorded[i] && clr_src == CLR_NONE) |=> $stable(rank_q[i])); // R4
  end

  assign cnt        = cnt_q;
  assign order_flat = rank_q;

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_src != CLR_NONE) |=> (order_flat == '0 && cnt_q == '0)); // R6

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= RANK_W'(NUM_EVT)); // R2

  AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_src == CLR_NONE) |=> (cnt_q >= $past(cnt_q))); // R7

endmodule

// File: rtl/evo_tmr_track.sv
// Per-timer completion tracking since that timer's last trigger.
module evo_tmr_track #(
  parameter int NUM_EVT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig,
  input  logic [NUM_EVT-1:0] own,
  input  logic [NUM_EVT-1:0] member,
  input  logic [NUM_EVT-1:0] hit,
  output logic               flag
);

  logic [NUM_EVT-1:0] cmp_q, cmp_d;
  logic               flag_q, flag_d;
  logic               all_done;
  logic               upd;

  always_comb begin
    if (trig) cmp_d = cmp_q & ~own;
    else      cmp_d = cmp_q | (hit & own);
  end

  assign all_done = (|member) && (&(cmp_d | ~member));

  always_comb begin
    if (trig) flag_d = 1'b0;
    else      flag_d = flag_q | all_done;
  end

  assign upd = trig || (|(hit & own)) || (flag_d != flag_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '0;
      flag_q <= 1'b0;
    end else if (upd) begin
      cmp_q  <= cmp_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  AST_TRIG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !flag); // R9

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !trig) |=> flag); // R8

  AST_TRIG_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> ((cmp_q & own) == '0)); // R9

endmodule

// File: rtl/evt_order_rec.sv
module evt_order_rec
  import evo_pkg::*;
#(
  parameter  int NUM_EVT = 16,
  parameter  int NUM_TMR = 2,
  localparam int RANK_W  = $clog2(NUM_EVT + 1),
  localparam int TSEL_W  = $clog2(NUM_TMR)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_EVT-1:0]        evt_done,
  input  logic [NUM_EVT-1:0]        evt_en,
  input  logic [NUM_EVT*TSEL_W-1:0] evt_tmr_flat,
  input  logic [NUM_TMR-1:0]        tmr_trig,
  input  logic                      sw_clr,
  input  logic                      auto_clr_en,
  input  logic [TSEL_W-1:0]         clr_trig_sel,
  input  logic [NUM_TMR-1:0]        irq_en,
  output logic [NUM_EVT*RANK_W-1:0] order_flat,
  output logic [NUM_TMR-1:0]        tmr_done,
  output logic [NUM_TMR-1:0]        irq
);

  clr_src_e                       clr_src;
  logic [NUM_EVT-1:0]             hit;
  logic [NUM_EVT-1:0]             recorded;
  logic [NUM_EVT-1:0]             fresh;
  logic [NUM_EVT-1:0][RANK_W-1:0] rank_new;
  logic [RANK_W-1:0]              total;
  logic [RANK_W-1:0]              cnt;

  always_comb begin
    if (sw_clr)                                clr_src = CLR_SW;
    else if (auto_clr_en && tmr_trig[clr_trig_sel]) clr_src = CLR_AUTO;
    else                                       clr_src = CLR_NONE;
  end

  assign hit   = evt_done & evt_en;
  assign fresh = hit & ~recorded;

  evo_rank_alloc #(.NUM_EVT(NUM_EVT), .RANK_W(RANK_W)) u_alloc (
    .fresh    (fresh),
    .base     (cnt),
    .rank_new (rank_new),
    .total    (total)
  );

  evo_order_regs #(.NUM_EVT(NUM_EVT), .RANK_W(RANK_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_src    (clr_src),
    .fresh      (fresh),
    .rank_new   (rank_new),
    .total      (total),
    .cnt        (cnt),
    .recorded   (recorded),
    .order_flat (order_flat)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    logic [NUM_EVT-1:0] own;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_own
      assign own[i] = (evt_tmr_flat[i*TSEL_W +: TSEL_W] == TSEL_W'(t));
    end

    evo_tmr_track #(.NUM_EVT(NUM_EVT)) u_trk (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig   (tmr_trig[t]),
      .own    (own),
      .member (own & evt_en),
      .hit    (hit),
      .flag   (tmr_done[t])
    );
  end

  assign irq = tmr_done & irq_en;

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_src == CLR_NONE && hit == '0) |=> $stable(order_flat)); // R5

  AST_OTHER_TRIG_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_clr && !auto_clr_en && evt_done == '0) |=> $stable(order_flat)); // R7

endmodule

// File: tb/evt_order_rec_bench.sv
module evt_order_rec_bench;

  localparam int NE = 16;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NE-1:0] evt_done, evt_en, evt_tmr_flat;
  logic [1:0]    tmr_trig, irq_en;
  logic          sw_clr, auto_clr_en;
  logic [0:0]    clr_trig_sel;
  logic [NE*RW-1:0] order_flat;
  logic [1:0]    tmr_done, irq;

  int checks = 0;
  int errors = 0;
  bit done_run = 1'b0;

  always #5 clk = ~clk;

  evt_order_rec u_evt_order_rec (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_done     (evt_done),
    .evt_en       (evt_en),
    .evt_tmr_flat (evt_tmr_flat),
    .tmr_trig     (tmr_trig),
    .sw_clr       (sw_clr),
    .auto_clr_en  (auto_clr_en),
    .clr_trig_sel (clr_trig_sel),
    .irq_en       (irq_en),
    .order_flat   (order_flat),
    .tmr_done     (tmr_done),
    .irq          (irq)
  );

  typedef struct {
    logic [NE*RW-1:0] ord;
    logic [1:0]       flg;
    string            tag;
  } exp_t;

  exp_t q[$];

  // Reference state kept from the requirements
  logic [RW-1:0] m_rank [NE];
  int            m_cnt;
  logic [NE-1:0] m_cmp;
  logic [1:0]    m_flag;

  task automatic check(input string tag, input string what,
                       input logic [NE*RW-1:0] act, input logic [NE*RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic [NE-1:0] d, input logic [1:0] t, input logic sw);
    logic clr;
    clr = sw | (auto_clr_en & t[clr_trig_sel]);
    for (int tm = 0; tm < 2; tm++) begin
      if (t[tm]) begin
        for (int i = 0; i < NE; i++) if (int'(evt_tmr_flat[i]) == tm) m_cmp[i] = 1'b0;
        m_flag[tm] = 1'b0;
      end else begin
        bit any, all;
        for (int i = 0; i < NE; i++)
          if (int'(evt_tmr_flat[i]) == tm && d[i] && evt_en[i]) m_cmp[i] = 1'b1;
        any = 0; all = 1;
        for (int i = 0; i < NE; i++)
          if (int'(evt_tmr_flat[i]) == tm && evt_en[i]) begin
            any = 1;
            if (!m_cmp[i]) all = 0;
          end
        if (any && all) m_flag[tm] = 1'b1;
      end
    end
    if (clr) begin
      for (int i = 0; i < NE; i++) m_rank[i] = '0;
      m_cnt = 0;
    end else begin
      for (int i = 0; i < NE; i++)
        if (d[i] && evt_en[i] && m_rank[i] == '0) begin
          m_cnt++;
          m_rank[i] = RW'(m_cnt);
        end
    end
  endtask

  // Driver: one cycle of stimulus, expectation queued for the monitor
  task automatic step(input logic [NE-1:0] d, input logic [1:0] t,
                      input logic sw, input string tag);
    exp_t e;
    @(negedge clk);
    evt_done = d;
    tmr_trig = t;
    sw_clr   = sw;
    model(d, t, sw);
    for (int i = 0; i < NE; i++) e.ord[i*RW +: RW] = m_rank[i];
    e.flg = m_flag;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares after each active edge, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "order", order_flat, e.ord);
        check(e.tag, "tmr_done", {78'd0, tmr_done}, {78'd0, e.flg});
        check((e.tag == "R8") ? "R10" : e.tag, "irq",
              {78'd0, irq}, {78'd0, e.flg & irq_en});
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done_run) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n        = 1'b0;
    evt_done     = '0;
    evt_en       = 16'hFFFF;
    evt_tmr_flat = 16'hFF00;
    tmr_trig     = '0;
    sw_clr       = 1'b0;
    auto_clr_en  = 1'b0;
    clr_trig_sel = 1'b0;
    irq_en       = 2'b11;
    for (int i = 0; i < NE; i++) m_rank[i] = '0;
    m_cnt  = 0;
    m_cmp  = '0;
    m_flag = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "order", order_flat, '0);
    check("R1", "tmr_done", {78'd0, tmr_done}, '0);
    check("R1", "irq", {78'd0, irq}, '0);
    rst_n  = 1'b1;
    irq_en = 2'b01;

    step(16'h0008, 2'b00, 1'b0, "R2");   // event 3 -> rank 1
    step(16'h0001, 2'b00, 1'b0, "R2");   // event 0 -> rank 2
    step(16'h0222, 2'b00, 1'b0, "R3");   // events 1,5,9 -> 3,4,5
    step(16'h0008, 2'b00, 1'b0, "R4");   // event 3 again, kept
    @(negedge clk); evt_en[7] = 1'b0;
    step(16'h0080, 2'b00, 1'b0, "R5");   // disabled event ignored
    step(16'h0054, 2'b00, 1'b0, "R8");   // timer 0 complete, irq0 (R10)
    step(16'h0000, 2'b10, 1'b0, "R7");   // trigger 1, auto off: no wipe
    step(16'h0000, 2'b01, 1'b0, "R9");   // trigger 0 drops flag 0
    step(16'h0400, 2'b00, 1'b1, "R6");   // software wipe beats completion
    step(16'h0000, 2'b00, 1'b0, "R6");
    @(negedge clk); auto_clr_en = 1'b1; clr_trig_sel = 1'b1;
    step(16'h0100, 2'b00, 1'b0, "R2");   // event 8 -> rank 1
    step(16'h0000, 2'b01, 1'b0, "R7");   // unselected trigger: no wipe
    step(16'h0000, 2'b10, 1'b0, "R7");   // selected trigger: wipe
    step(16'hFF00, 2'b00, 1'b0, "R3");   // events 8..15 -> 1..8, flag 1
    @(negedge clk); irq_en = 2'b11;
    step(16'h0000, 2'b00, 1'b0, "R10");
    step(16'h0200, 2'b10, 1'b0, "R9");   // trigger with completion
    step(16'h0000, 2'b00, 1'b0, "R9");
    step(16'h0000, 2'b00, 1'b0, "R10");
    @(negedge clk);
    evt_done = '0; tmr_trig = '0; sw_clr = 1'b0;
    repeat (3) @(negedge clk);
    done_run = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule